// File: doc/BRIEF.md
# Keyed I/O Configuration Unlock for an 8-bit Peripheral Bus

This block sits on the peripheral side of an 8-bit, ISA-style I/O bus. It keeps the adapter hidden until a five-byte key has been written. The first key byte goes to one fixed port. The remaining four go, in order, to a second fixed port. The next write to the second port is then taken as a packed configuration byte.

The configuration byte either enables the adapter or disables it. When it enables the adapter, it also picks one of eight base addresses and an interrupt line. Once enabled, the block decodes a 16-byte I/O window at the chosen base. It exposes a one-bit probe register inside that window, so software can confirm the adapter is present. While the window is not decoding, every read returns 0xFF. This lets software scan candidate bases for a free one.

Two parameters pick the build variant. One selects which of two keys unlocks the unit. The other selects which of two base-address tables the index points into.

Top module: `isa_key_cfg`

## Requirements
- R1: After reset, `cfg_en` is 0, `cfg_idx` is 0, `cfg_irq` is 0 and `win_hit` is 0.
- R2: The key is one byte written to port 0x779 followed by four bytes written to port 0x379. The build selects the key: KEY_SEL=0 uses 59 B9 C5 AE A6, and KEY_SEL=1 uses 0F 22 F0 20 80. After the key, the next write to 0x379 with bit 7 set makes `cfg_en`=1 and `cfg_idx`=bits 2:0, one cycle after the write.
- R3: A configuration byte with bit 7 clear (for example 0x00) sets `cfg_en`=0 and `cfg_irq`=0 and keeps `cfg_idx`. The window then stops decoding.
- R4: `cfg_irq` takes configuration bits 6:4 when they equal 2, 3, 4, 5 or 7. Any other value gives 0. Bit 3 is ignored.
- R5: A key byte that does not match, or any key of the variant the build did not select, returns the matcher to idle. Later writes to 0x379 then change no output until a full key is written again.
- R6: A matching first byte at 0x779 restarts the match from step one at any point in the sequence.
- R7: A write to 0x379 while the matcher is idle changes no output.
- R8: Index 0..7 selects the base from 0x280, 0x290, 0x300, 0x310, 0x330, 0x340, 0x348, 0x350 (TABLE_SEL=0) or from 0x220, 0x240, 0x280, 0x2A0, 0x2C0, 0x300, 0x320, 0x340 (TABLE_SEL=1). `win_hit` is 1 for addresses base..base+15 while enabled, and 0 at base-1 and at base+16.
- R9: `io_rdata` is 0xFF whenever `io_rd` is low or `win_hit` is 0.
- R10: Inside the window, a read at offset 9 returns {probe bit, 7'b0} and any other offset reads 0x00. A write at offset 9 loads the probe bit from data bit 7, so writing 0xC0 reads back as 0x80. The probe bit clears only on reset.
- R11: Taking the configuration byte returns the matcher to idle, so a further write to 0x379 is not applied.
- R12: Writes to addresses other than the two key ports do not disturb a match in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (0xFF when not decoding) |
| cfg_en | output | 1 | Adapter enabled |
| cfg_idx | output | 3 | Selected base-address index |
| cfg_irq | output | 3 | Selected interrupt number, 0 for none |
| win_hit | output | 1 | Address falls in the enabled 16-byte window |

## Verification
The bench builds the block with KEY_SEL=1 and TABLE_SEL=1. This puts the alternate key and the alternate base table under test. It also lets the bench show that the default key does not unlock that build. The bench walks all eight indexes against the table, checking both edges of each window, and runs every interrupt field value class through the filter. The default variant pair is covered by elaborating the block with its default parameters.

// File: rtl/isa_key_pkg.sv
package isa_key_pkg;
   localparam int IDX_W   = 3;
   localparam int IRQ_W   = 3;
   localparam int KEY_LEN = 5;

   typedef enum logic [2:0] {
      KM_IDLE  = 3'd0,
      KM_K1    = 3'd1,
      KM_K2    = 3'd2,
      KM_K3    = 3'd3,
      KM_K4    = 3'd4,
      KM_ARMED = 3'd5
   } km_state_t;

   typedef struct packed {
      logic             en;
      logic [IDX_W-1:0] idx;
      logic [IRQ_W-1:0] irq;
   } cfg_t;

   // interrupt lines the adapter may drive; everything else maps to none
   function automatic logic [IRQ_W-1:0] irq_filter(input logic [IRQ_W-1:0] v);
      case (v)
         3'd2, 3'd3, 3'd4, 3'd5, 3'd7: irq_filter = v;
         default:                       irq_filter = '0;
      endcase
   endfunction
endpackage

// File: rtl/isa_key_matcher.sv
module isa_key_matcher
   import isa_key_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int FIRST_PORT = 'h779,
   parameter int SEQ_PORT   = 'h379,
   parameter int KEY_SEL    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   output logic              cfg_stb
);
   localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(FIRST_PORT);
   localparam logic [ADDR_W-1:0] SEQ_A   = ADDR_W'(SEQ_PORT);

   logic [KEY_LEN-1:0][7:0] key;

   generate
      if (KEY_SEL == 0) begin : g_key_main
         assign key = {8'hA6, 8'hAE, 8'hC5, 8'hB9, 8'h59};
      end else begin : g_key_alt
         assign key = {8'h80, 8'h20, 8'hF0, 8'h22, 8'h0F};
      end
   endgenerate

   km_state_t state_q, state_d;
   logic [7:0] expect_b;

   always_comb begin
      case (state_q)
         KM_K1:   expect_b = key[1];
         KM_K2:   expect_b = key[2];
         KM_K3:   expect_b = key[3];
         KM_K4:   expect_b = key[4];
         default: expect_b = key[0];
      endcase
   end

   always_comb begin
      state_d = state_q;
      cfg_stb = 1'b0;
      if (io_wr) begin
         if (io_addr == FIRST_A) begin
            state_d = (io_wdata == key[0]) ? KM_K1 : KM_IDLE;
         end else if (io_addr == SEQ_A) begin
            case (state_q)
               KM_IDLE:  state_d = KM_IDLE;
               KM_ARMED: begin
                  cfg_stb = 1'b1;
                  state_d = KM_IDLE;
               end
               default:  state_d = (io_wdata == expect_b)
                                   ? km_state_t'(state_q + 3'd1) : KM_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KM_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/isa_cfg_store.sv
module isa_cfg_store
   import isa_key_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_stb,
   input  logic [7:0]       cfg_byte,
   output logic             cfg_en,
   output logic [IDX_W-1:0] cfg_idx,
   output logic [IRQ_W-1:0] cfg_irq
);
   cfg_t cur_q;
   logic unused_bit3;

   assign unused_bit3 = cfg_byte[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else if (cfg_stb) begin
         if (cfg_byte[7]) begin
            cur_q.en  <= 1'b1;
            cur_q.idx <= cfg_byte[IDX_W-1:0];
            cur_q.irq <= irq_filter(cfg_byte[4 +: IRQ_W]);
         end else begin
            cur_q.en  <= 1'b0;
            cur_q.irq <= '0;
         end
      end
   end

   assign cfg_en  = cur_q.en;
   assign cfg_idx = cur_q.idx;
   assign cfg_irq = cur_q.irq;
endmodule

// File: rtl/isa_base_decode.sv
module isa_base_decode
   import isa_key_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int TABLE_SEL = 0,
   parameter int WIN_BYTES = 16,
   parameter int PROBE_OFS = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic              hit,
   output logic [7:0]        rdata
);
   localparam logic [ADDR_W-1:0] WIN_A   = ADDR_W'(WIN_BYTES);
   localparam logic [ADDR_W-1:0] PROBE_A = ADDR_W'(PROBE_OFS);

   logic [11:0]       base12;
   logic [ADDR_W-1:0] base_a, offs;
   logic              probe_q, at_probe;

   generate
      if (TABLE_SEL == 0) begin : g_tab_main
         always_comb begin
            case (idx)
               3'd0: base12 = 12'h280;
               3'd1: base12 = 12'h290;
               3'd2: base12 = 12'h300;
               3'd3: base12 = 12'h310;
               3'd4: base12 = 12'h330;
               3'd5: base12 = 12'h340;
               3'd6: base12 = 12'h348;
               default: base12 = 12'h350;
            endcase
         end
      end else begin : g_tab_alt
         always_comb begin
            case (idx)
               3'd0: base12 = 12'h220;
               3'd1: base12 = 12'h240;
               3'd2: base12 = 12'h280;
               3'd3: base12 = 12'h2A0;
               3'd4: base12 = 12'h2C0;
               3'd5: base12 = 12'h300;
               3'd6: base12 = 12'h320;
               default: base12 = 12'h340;
            endcase
         end
      end
   endgenerate

   // subtract-and-compare: some bases are not aligned to the window size
   assign base_a   = ADDR_W'(base12);
   assign offs     = io_addr - base_a;
   assign hit      = en && (io_addr >= base_a) && (offs < WIN_A);
   assign at_probe = hit && (offs == PROBE_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  probe_q <= 1'b0;
      else if (io_wr && at_probe)  probe_q <= io_wdata[7];
   end

   always_comb begin
      if (!io_rd || !hit) rdata = 8'hFF;
      else if (at_probe)  rdata = {probe_q, 7'b0};
      else                rdata = 8'h00;
   end
endmodule

// File: rtl/isa_key_cfg.sv
module isa_key_cfg
   import isa_key_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int KEY_SEL    = 0,
   parameter int TABLE_SEL  = 0,
   parameter int WIN_BYTES  = 16,
   parameter int PROBE_OFS  = 9,
   parameter int FIRST_PORT = 'h779,
   parameter int SEQ_PORT   = 'h379
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic              cfg_en,
   output logic [2:0]        cfg_idx,
   output logic [2:0]        cfg_irq,
   output logic              win_hit
);
   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("isa_key_cfg: ADDR_W must reach the key ports");
      end
      if (KEY_SEL < 0 || KEY_SEL > 1) begin : g_bad_key
         $error("isa_key_cfg: KEY_SEL must be 0 or 1");
      end
      if (TABLE_SEL < 0 || TABLE_SEL > 1) begin : g_bad_tab
         $error("isa_key_cfg: TABLE_SEL must be 0 or 1");
      end
      if (WIN_BYTES < 16 || (WIN_BYTES & (WIN_BYTES - 1)) != 0) begin : g_bad_win
         $error("isa_key_cfg: WIN_BYTES must be a power of two of at least 16");
      end
      if (PROBE_OFS < 0 || PROBE_OFS >= WIN_BYTES) begin : g_bad_probe
         $error("isa_key_cfg: PROBE_OFS must lie inside the window");
      end
   endgenerate

   logic cfg_stb;

   isa_key_matcher #(
      .ADDR_W    (ADDR_W),
      .FIRST_PORT(FIRST_PORT),
      .SEQ_PORT  (SEQ_PORT),
      .KEY_SEL   (KEY_SEL)
   ) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_addr (io_addr),
      .io_wr   (io_wr),
      .io_wdata(io_wdata),
      .cfg_stb (cfg_stb)
   );

   isa_cfg_store u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_stb (cfg_stb),
      .cfg_byte(io_wdata),
      .cfg_en  (cfg_en),
      .cfg_idx (cfg_idx),
      .cfg_irq (cfg_irq)
   );

   isa_base_decode #(
      .ADDR_W   (ADDR_W),
      .TABLE_SEL(TABLE_SEL),
      .WIN_BYTES(WIN_BYTES),
      .PROBE_OFS(PROBE_OFS)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cfg_en),
      .idx     (cfg_idx),
      .io_addr (io_addr),
      .io_wr   (io_wr),
      .io_rd   (io_rd),
      .io_wdata(io_wdata),
      .hit     (win_hit),
      .rdata   (io_rdata)
   );
endmodule

// File: rtl/isa_key_cfg_chk.sv
module isa_key_cfg_chk #(
   parameter int ADDR_W   = 16,
   parameter int SEQ_PORT = 'h379
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_rdata,
   input logic              cfg_en,
   input logic [2:0]        cfg_idx,
   input logic [2:0]        cfg_irq,
   input logic              win_hit
);
   localparam logic [ADDR_W-1:0] SEQ_A = ADDR_W'(SEQ_PORT);

   // R4: only the permitted interrupt numbers ever appear
   p_irq_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_irq == 3'd0) || (cfg_irq == 3'd2) || (cfg_irq == 3'd3) ||
      (cfg_irq == 3'd4) || (cfg_irq == 3'd5) || (cfg_irq == 3'd7));

   // R3: disabled adapter carries no interrupt and decodes nothing
   p_off_no_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |-> (cfg_irq == 3'd0));
   p_hit_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> cfg_en);

   // R2: enable changes only after a write to the sequence port
   p_en_from_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_en) |-> ($past(io_wr) && ($past(io_addr) == SEQ_A)));

   // R3: index changes only after a write to the sequence port
   p_idx_from_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_idx) |-> ($past(io_wr) && ($past(io_addr) == SEQ_A)));

   // R9: idle bus reads all ones
   p_idle_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_rd || !win_hit) |-> (io_rdata == 8'hFF));
endmodule

bind isa_key_cfg isa_key_cfg_chk #(
   .ADDR_W  (ADDR_W),
   .SEQ_PORT(SEQ_PORT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .io_addr (io_addr),
   .io_wr   (io_wr),
   .io_rd   (io_rd),
   .io_rdata(io_rdata),
   .cfg_en  (cfg_en),
   .cfg_idx (cfg_idx),
   .cfg_irq (cfg_irq),
   .win_hit (win_hit)
);

// File: tb/isa_key_cfg_tb.sv
module isa_key_cfg_tb;
   localparam int CLK_P = 10;
   localparam int KSEL  = 1;
   localparam int TSEL  = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = 16'h0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h0;
   logic [7:0]  io_rdata;
   logic        cfg_en, win_hit;
   logic [2:0]  cfg_idx, cfg_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int key_q[$];
   int bad_q[$];
   int base_q[$];

   // reference model state
   int m_st = 0, m_en = 0, m_idx = 0, m_irq = 0, m_probe = 0;

   always #(CLK_P/2) clk = ~clk;

   isa_key_cfg #(.ADDR_W(16), .KEY_SEL(KSEL), .TABLE_SEL(TSEL)) u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .cfg_en(cfg_en), .cfg_idx(cfg_idx), .cfg_irq(cfg_irq), .win_hit(win_hit)
   );

   initial begin
      if (KSEL == 1) begin
         key_q = '{'h0F, 'h22, 'hF0, 'h20, 'h80};
         bad_q = '{'h59, 'hB9, 'hC5, 'hAE, 'hA6};
      end else begin
         key_q = '{'h59, 'hB9, 'hC5, 'hAE, 'hA6};
         bad_q = '{'h0F, 'h22, 'hF0, 'h20, 'h80};
      end
      if (TSEL == 1) base_q = '{'h220, 'h240, 'h280, 'h2A0, 'h2C0, 'h300, 'h320, 'h340};
      else           base_q = '{'h280, 'h290, 'h300, 'h310, 'h330, 'h340, 'h348, 'h350};
   end

   function automatic int m_hit(input int a);
      int b;
      b = base_q[m_idx];
      return (m_en != 0 && a >= b && a < b + 16) ? 1 : 0;
   endfunction

   function automatic int m_rdata(input int a, input int rd);
      if (rd == 0 || m_hit(a) == 0) return 'hFF;
      if (a - base_q[m_idx] == 9) return m_probe << 7;
      return 0;
   endfunction

   function automatic int legal_irq(input int v);
      return (v == 2 || v == 3 || v == 4 || v == 5 || v == 7) ? v : 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_en = 0; m_idx = 0; m_irq = 0; m_probe = 0;
      end else if (io_wr) begin
         if (m_hit(int'(io_addr)) != 0 && int'(io_addr) - base_q[m_idx] == 9)
            m_probe = int'(io_wdata[7]);
         if (io_addr == 16'h779) begin
            m_st = (int'(io_wdata) == key_q[0]) ? 1 : 0;
         end else if (io_addr == 16'h379) begin
            if (m_st == 5) begin
               if (io_wdata[7]) begin
                  m_en = 1; m_idx = int'(io_wdata[2:0]);
                  m_irq = legal_irq(int'(io_wdata[6:4]));
               end else begin
                  m_en = 0; m_irq = 0;
               end
               m_st = 0;
            end else if (m_st >= 1) begin
               m_st = (int'(io_wdata) == key_q[m_st]) ? m_st + 1 : 0;
            end
         end
      end
   end

   task automatic cmp(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // every cycle: compare against the behavioural model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         #(CLK_P/4);
         cmp("R2 model cfg_en", int'(cfg_en), m_en);
         cmp("R2 model cfg_idx", int'(cfg_idx), m_idx);
         cmp("R4 model cfg_irq", int'(cfg_irq), m_irq);
         cmp("R8 model win_hit", int'(win_hit), m_hit(int'(io_addr)));
         cmp("R9 model io_rdata", int'(io_rdata), m_rdata(int'(io_addr), int'(io_rd)));
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      io_addr = 16'(a); io_wdata = 8'(d); io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_addr = 16'h0;
   endtask

   task automatic rd_exp(input int a, input int exp, input string tag);
      @(negedge clk);
      io_addr = 16'(a); io_rd = 1'b1;
      #(CLK_P/4);
      cmp(tag, int'(io_rdata), exp);
      @(negedge clk);
      io_rd = 1'b0; io_addr = 16'h0;
   endtask

   task automatic cfg_exp(input int en, input int idx, input int irq, input string tag);
      #1;
      cmp({tag, " en"}, int'(cfg_en), en);
      cmp({tag, " idx"}, int'(cfg_idx), idx);
      cmp({tag, " irq"}, int'(cfg_irq), irq);
   endtask

   task automatic unlock_cfg(input int cfg);
      wr('h779, key_q[0]);
      for (int i = 1; i < 5; i++) wr('h379, key_q[i]);
      wr('h379, cfg);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cfg_exp(0, 0, 0, "R1 reset");
      cmp("R1 reset hit", int'(win_hit), 0);
      rd_exp('h220, 'hFF, "R9 read while disabled");

      // R2: full key, enable at index 2, irq 3
      unlock_cfg('hB2);
      cfg_exp(1, 2, 3, "R2 enable");
      rd_exp(base_q[2], 'h00, "R10 window offset 0");
      rd_exp(base_q[2] - 1, 'hFF, "R8 below base");
      rd_exp(base_q[2] + 15, 'h00, "R8 last byte");
      rd_exp(base_q[2] + 16, 'hFF, "R8 past window");

      // R10: probe register
      wr(base_q[2] + 9, 'hC0);
      rd_exp(base_q[2] + 9, 'h80, "R10 probe readback");

      // R4: interrupt filter
      unlock_cfg('hE5); cfg_exp(1, 5, 0, "R4 irq6 dropped");
      unlock_cfg('hF5); cfg_exp(1, 5, 7, "R4 irq7 kept");
      unlock_cfg('h9D); cfg_exp(1, 5, 0, "R4 irq1 dropped bit3 ignored");
      unlock_cfg('hC1); cfg_exp(1, 1, 4, "R4 irq4 kept");

      // R3: disable keeps index
      unlock_cfg('h00); cfg_exp(0, 1, 0, "R3 disable");
      rd_exp(base_q[1], 'hFF, "R3 window off");

      // R5: wrong byte mid-key
      wr('h779, key_q[0]); wr('h379, key_q[1]); wr('h379, key_q[2] ^ 'h01);
      wr('h379, key_q[3]); wr('h379, key_q[4]); wr('h379, 'h97);
      cfg_exp(0, 1, 0, "R5 wrong byte");
      // R5: key of the other variant
      wr('h779, bad_q[0]);
      for (int i = 1; i < 5; i++) wr('h379, bad_q[i]);
      wr('h379, 'h97);
      cfg_exp(0, 1, 0, "R5 other variant key");

      // R6: restart on first byte
      wr('h779, key_q[0]); wr('h379, key_q[1]);
      unlock_cfg('h87);
      cfg_exp(1, 7, 0, "R6 restart");

      // R11: config consumed, matcher idle
      wr('h379, 'hB0);
      cfg_exp(1, 7, 0, "R11 second config ignored");

      // R7: idle sequence-port write
      wr('h379, 'h84);
      cfg_exp(1, 7, 0, "R7 idle write");

      // R12: unrelated write inside the key
      wr('h779, key_q[0]); wr('h379, key_q[1]); wr('h100, 'h55);
      wr('h379, key_q[2]); wr('h379, key_q[3]); wr('h100, 'hAA);
      wr('h379, key_q[4]); wr('h379, 'hA3);
      cfg_exp(1, 3, 2, "R12 foreign write");

      // R8: every index against the table
      for (int i = 0; i < 8; i++) begin
         unlock_cfg('h80 | i);
         cfg_exp(1, i, 0, "R8 index load");
         rd_exp(base_q[i], 'h00, "R8 base decode");
         rd_exp(base_q[i] + 16, (i < 7 && base_q[i + 1] == base_q[i] + 16) ? 'h00 : 'hFF,
                "R8 window end");
      end

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule